// File: doc/BRIEF.md
# Bit-Serial Folded FIR Filter

This block is a finite impulse response filter that keeps its area small by working through each sample one bit slot per clock. A parallel input word arrives on `din` with a one-cycle `irdy` qualifier. It enters a shift chain of taps. Mirrored tap pairs are combined before the multiply: summed for an even (symmetric) response, differenced for an odd (anti-symmetric) response. With no symmetry the pairs are not combined. Each combined operand is then consumed least significant bit first. In every bit slot one multiplier per folded tap contributes a shifted coefficient, and a binary adder tree merges those contributions into an accumulator.

A result takes as many bit slots as the full-precision width, so the filter can start a new sample only once per processing period. The finished sum is scaled down to the requested output width, either by truncation or by rounding to nearest. It then leaves on `dout`, marked by a one-clock `ordy` pulse. Coefficients come from a parameter at reset and, when loading is enabled, can be replaced at run time by shifting words in through `coeff`/`loadc`.

Top module: `bsfir_top`

## Requirements
- R1: With NF folded taps (NTAPS/2 when symmetric or anti-symmetric, NTAPS otherwise), the full width is FW = 2*DW + clog2(NF) + 1 and the processing period is P = FW + 1 clocks. A sample is accepted on an `irdy` edge only when no period is running. An `irdy` pulse that arrives during a running period is ignored and produces no result.
- R2: The tap chain holds NTAPS words. On acceptance, position 0 takes `din` and every other position takes its lower neighbour. Reset clears all taps to zero.
- R3: In even symmetry (SYM=1), result y = sum over k<NF of c[k]*(x[k] + x[NTAPS-1-k]). Here x[0] is the newest accepted sample.
- R4: In odd symmetry (SYM=2), y = sum over k<NF of c[k]*(x[k] - x[NTAPS-1-k]), and the fold stage takes one extra clock.
- R5: With no symmetry (SYM=0), y = sum over k<NTAPS of c[k]*x[k]. Data and coefficients are unsigned when SIGNED=0 and signed otherwise. Even and odd symmetry always use signed arithmetic.
- R6: The coefficient store has NF words. Word k is reset from bits [k*DW +: DW] of COEF_INIT. When LOADABLE=1, each clock with `loadc` high moves word k to k+1 and writes `coeff` into word 0. When LOADABLE=0, `coeff`/`loadc` have no effect.
- R7: With S = FW - OW and ROUND=0, `dout` = floor(y / 2^S), kept to OW bits. With ROUND=1, `dout` = floor((y + 2^(S-1)) / 2^S); when S=0 the added term is 0.
- R8: `ordy` rises exactly FW + 3 + (1 if SYM=2) + ROUND clock edges after the edge that accepted the sample.
- R9: `ordy` is high for one clock per result, and `dout` changes only on the edge that raises `ordy`.
- R10: After reset, `dout` is zero and `ordy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DW | Input sample |
| irdy | input | 1 | Sample valid qualifier |
| coeff | input | DW | Coefficient word to load |
| loadc | input | 1 | Shift `coeff` into the coefficient store |
| dout | output | OW | Scaled filter result |
| ordy | output | 1 | One-clock result strobe |

## Verification
The bench runs three small filters side by side: an even one with rounding, an odd one with truncation, and an unsigned one without symmetry whose coefficients are fixed. It sweeps every pair of consecutive input values, so the fold sign and the sign extension in the upper bit slots are exercised at both extremes. A sign-extension error would give wrong negative results; a fold that added instead of subtracting would give the wrong odd result. The bench loads extreme coefficients, including the most negative one, to catch a coefficient left unsigned. It places `irdy` pulses inside a running period, so a design that accepted them would shift the taps and emit extra results. It writes coefficients to the fixed-coefficient filter, so a design that let them through would change that filter's output. It times every result from its accepting edge, which exposes a missing or an extra pipeline stage in the odd fold or the rounding path.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_EVEN = 2'd1,
        SYM_ODD  = 2'd2
    } sym_e;

    // number of multipliers after mirrored-pair folding
    function automatic int fold_count(input int ntaps, input sym_e sym);
        return (sym == SYM_NONE) ? ntaps : ntaps / 2;
    endfunction

    // full-precision accumulator width
    function automatic int full_width(input int dw, input int nf);
        return 2 * dw + $clog2(nf) + 1;
    endfunction

endpackage

// File: rtl/bsf_taps.sv
module bsf_taps #(
    parameter int            DW    = 8,
    parameter int            NTAPS = 16,
    parameter bsf_pkg::sym_e SYM   = bsf_pkg::SYM_EVEN,
    parameter int            NF    = 8,
    parameter bit            SGN   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic [DW-1:0]        din,
    output logic [NF-1:0][DW:0]  fold,
    output logic [DW-1:0]        tap0
);
    // odd symmetry spends one more register on the subtract path
    localparam int FD = (SYM == bsf_pkg::SYM_ODD) ? 2 : 1;

    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0]      tap;
        logic [FD-1:0][NF-1:0][DW:0]   fp;
    } taps_t;

    taps_t q, d;

    function automatic logic [DW:0] ext(input logic [DW-1:0] v);
        return SGN ? {v[DW-1], v} : {1'b0, v};
    endfunction

    always_comb begin
        d = q;
        if (shift) begin
            d.tap[0] = din;
            for (int i = 1; i < NTAPS; i++) begin
                d.tap[i] = q.tap[i-1];
            end
        end
        for (int k = 0; k < NF; k++) begin
            case (SYM)
                bsf_pkg::SYM_EVEN: d.fp[0][k] = ext(q.tap[k]) + ext(q.tap[NTAPS-1-k]);
                bsf_pkg::SYM_ODD:  d.fp[0][k] = ext(q.tap[k]) - ext(q.tap[NTAPS-1-k]);
                default:           d.fp[0][k] = ext(q.tap[k]);
            endcase
        end
        for (int j = 1; j < FD; j++) begin
            d.fp[j] = q.fp[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fold = q.fp[FD-1];
    assign tap0 = q.tap[0];

endmodule

// File: rtl/bsf_coefs.sv
module bsf_coefs #(
    parameter int              DW        = 8,
    parameter int              NF        = 8,
    parameter int              NTAPS     = 16,
    parameter bit              LOADABLE  = 1'b1,
    parameter logic [NTAPS*DW-1:0] COEF_INIT = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loadc,
    input  logic [DW-1:0]           coeff,
    output logic [NF-1:0][DW-1:0]   coefs
);
    typedef struct packed {
        logic [NF-1:0][DW-1:0] word;
    } cst_t;

    cst_t q, d;
    cst_t init_v;

    always_comb begin
        for (int k = 0; k < NF; k++) begin
            init_v.word[k] = COEF_INIT[k*DW +: DW];
        end
    end

    always_comb begin
        d = q;
        if (LOADABLE && loadc) begin
            d.word[0] = coeff;
            for (int k = 1; k < NF; k++) begin
                d.word[k] = q.word[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= init_v;
        end else begin
            q <= d;
        end
    end

    assign coefs = q.word;

endmodule

// File: rtl/bsf_mac.sv
module bsf_mac #(
    parameter int DW  = 8,
    parameter int NF  = 8,
    parameter int FW  = 20,
    parameter bit SGN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [NF-1:0][DW:0]    fold,
    input  logic [NF-1:0][DW-1:0]  coefs,
    output logic [FW-1:0]          acc,
    output logic                   done
);
    localparam int CW = $clog2(FW + 1);
    localparam int NL = 1 << $clog2(NF);

    typedef struct packed {
        logic [NF-1:0][FW-1:0] sh;
        logic [NF-1:0][FW-1:0] mc;
        logic [FW-1:0]         acc;
        logic [CW-1:0]         cnt;
        logic                  done;
    } mac_t;

    mac_t q, d;
    logic [NL-1:0][FW-1:0] leaf;
    logic [FW-1:0]         slot_sum;

    // pairwise reduction, one adder level per halving
    function automatic logic [FW-1:0] tree_sum(input logic [NL-1:0][FW-1:0] lv);
        logic [NL-1:0][FW-1:0] v;
        v = lv;
        for (int w = NL / 2; w > 0; w = w / 2) begin
            for (int i = 0; i < w; i++) begin
                v[i] = v[2*i] + v[2*i+1];
            end
        end
        return v[0];
    endfunction

    always_comb begin
        leaf = '0;
        for (int k = 0; k < NF; k++) begin
            leaf[k] = q.sh[k][0] ? q.mc[k] : '0;
        end
        slot_sum = tree_sum(leaf);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load) begin
            for (int k = 0; k < NF; k++) begin
                d.sh[k] = {{(FW-DW-1){fold[k][DW]}}, fold[k]};
                d.mc[k] = {{(FW-DW){SGN & coefs[k][DW-1]}}, coefs[k]};
            end
            d.acc = '0;
            d.cnt = CW'(FW);
        end else if (q.cnt != '0) begin
            for (int k = 0; k < NF; k++) begin
                d.sh[k] = q.sh[k] >> 1;
                d.mc[k] = q.mc[k] << 1;
            end
            d.acc  = q.acc + slot_sum;
            d.cnt  = q.cnt - CW'(1);
            d.done = (q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc  = q.acc;
    assign done = q.done;

endmodule

// File: rtl/bsf_out.sv
module bsf_out #(
    parameter int FW    = 20,
    parameter int OW    = 16,
    parameter bit ROUND = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [FW-1:0] acc,
    output logic [OW-1:0] dout,
    output logic          ordy
);
    localparam int            SH   = FW - OW;
    localparam logic [FW-1:0] HALF = (SH == 0) ? '0 : (FW'(1) << ((SH > 0) ? SH - 1 : 0));

    generate
        if (ROUND) begin : g_round
            typedef struct packed {
                logic [FW-1:0] rs;
                logic          rv;
                logic [OW-1:0] dout;
                logic          ordy;
            } ro_t;

            ro_t q, d;

            always_comb begin
                d      = q;
                d.rv   = done;
                d.ordy = q.rv;
                if (done) begin
                    d.rs = acc + HALF;
                end
                if (q.rv) begin
                    d.dout = q.rs[FW-1 -: OW];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end

            assign dout = q.dout;
            assign ordy = q.ordy;
        end else begin : g_trunc
            typedef struct packed {
                logic [OW-1:0] dout;
                logic          ordy;
            } to_t;

            to_t q, d;

            always_comb begin
                d      = q;
                d.ordy = done;
                if (done) begin
                    d.dout = acc[FW-1 -: OW];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end

            assign dout = q.dout;
            assign ordy = q.ordy;
        end
    endgenerate

endmodule

// File: rtl/bsfir_top.sv
module bsfir_top #(
    parameter int                    DW        = 8,
    parameter int                    NTAPS     = 16,
    parameter bsf_pkg::sym_e         SYM       = bsf_pkg::SYM_EVEN,
    parameter bit                    SIGNED    = 1'b1,
    parameter bit                    LOADABLE  = 1'b1,
    parameter int                    OW        = 16,
    parameter bit                    ROUND     = 1'b1,
    parameter logic [NTAPS*DW-1:0]   COEF_INIT = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  din,
    input  logic           irdy,
    input  logic [DW-1:0]  coeff,
    input  logic           loadc,
    output logic [OW-1:0]  dout,
    output logic           ordy
);
    localparam int NF  = bsf_pkg::fold_count(NTAPS, SYM);
    localparam int FW  = bsf_pkg::full_width(DW, NF);
    localparam int P   = FW + 1;
    localparam bit SGN = SIGNED || (SYM != bsf_pkg::SYM_NONE);
    localparam int PRE = (SYM == bsf_pkg::SYM_ODD) ? 2 : 1;
    localparam int TW  = PRE + 1;
    localparam int PW  = $clog2(P + 1);

    typedef struct packed {
        logic [PW-1:0] pc;
        logic [TW-1:0] tok;
    } ctl_t;

    ctl_t q, d;
    logic accept;
    logic busy;
    logic load;

    logic [NF-1:0][DW:0]   fold;
    logic [NF-1:0][DW-1:0] coefs;
    logic [FW-1:0]         acc;
    logic                  done;
    logic [DW-1:0]         tap0_w;
    logic [DW-1:0]         coef0_w;

    assign busy   = (q.pc != '0);
    assign accept = irdy && !busy;
    assign load   = q.tok[TW-1];

    always_comb begin
        d     = q;
        d.tok = TW'({q.tok, accept});
        if (accept) begin
            d.pc = PW'(P - 1);
        end else if (busy) begin
            d.pc = q.pc - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    bsf_taps #(
        .DW(DW), .NTAPS(NTAPS), .SYM(SYM), .NF(NF), .SGN(SGN)
    ) u_taps (
        .clk(clk), .rst_n(rst_n), .shift(accept), .din(din),
        .fold(fold), .tap0(tap0_w)
    );

    bsf_coefs #(
        .DW(DW), .NF(NF), .NTAPS(NTAPS), .LOADABLE(LOADABLE), .COEF_INIT(COEF_INIT)
    ) u_coefs (
        .clk(clk), .rst_n(rst_n), .loadc(loadc), .coeff(coeff), .coefs(coefs)
    );

    assign coef0_w = coefs[0];

    bsf_mac #(
        .DW(DW), .NF(NF), .FW(FW), .SGN(SGN)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .load(load), .fold(fold), .coefs(coefs),
        .acc(acc), .done(done)
    );

    bsf_out #(
        .FW(FW), .OW(OW), .ROUND(ROUND)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .done(done), .acc(acc),
        .dout(dout), .ordy(ordy)
    );

endmodule

// File: rtl/bsf_chk.sv
module bsf_chk #(
    parameter int DW       = 8,
    parameter int OW       = 16,
    parameter int P        = 21,
    parameter bit LOADABLE = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irdy,
    input logic [DW-1:0] din,
    input logic          busy,
    input logic [DW-1:0] tap0,
    input logic          loadc,
    input logic [DW-1:0] coef0,
    input logic [OW-1:0] dout,
    input logic          ordy
);
    logic [15:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 16'(P);
        end else if (ordy) begin
            gap_q <= '0;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    p_take_din_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && !busy) |=> (tap0 == $past(din)));

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && !busy) |=> busy);

    p_ignore_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tap0));

    p_result_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ordy |-> (gap_q >= 16'(P - 1)));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ordy |=> !ordy);

    p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ordy |-> $stable(dout));

    p_coef_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(LOADABLE && loadc) |=> $stable(coef0));

endmodule

bind bsfir_top bsf_chk #(
    .DW(DW), .OW(OW), .P(P), .LOADABLE(LOADABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irdy(irdy), .din(din), .busy(busy),
    .tap0(tap0_w), .loadc(loadc), .coef0(coef0_w), .dout(dout), .ordy(ordy)
);

// File: tb/sim_bsfir_top.sv
module sim_bsfir_top;
    localparam int LAT = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] din = '0;
    logic       irdy = 1'b0;
    logic [3:0] coeff = '0;
    logic       loadc = 1'b0;
    logic [6:0]  dout0;
    logic [8:0]  dout1;
    logic [11:0] dout2;
    logic ordy0, ordy1, ordy2;

    always #5 clk = ~clk;

    // even, rounding, 11-bit full width scaled to 7
    bsfir_top #(.DW(4), .NTAPS(6), .SYM(bsf_pkg::SYM_EVEN), .SIGNED(1'b1), .LOADABLE(1'b1),
                .OW(7), .ROUND(1'b1), .COEF_INIT(24'h0005D2)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .irdy(irdy), .coeff(coeff), .loadc(loadc),
        .dout(dout0), .ordy(ordy0));

    // odd, truncation, 11-bit full width scaled to 9
    bsfir_top #(.DW(4), .NTAPS(6), .SYM(bsf_pkg::SYM_ODD), .SIGNED(1'b1), .LOADABLE(1'b1),
                .OW(9), .ROUND(1'b0), .COEF_INIT(24'h0005D2)) u1 (
        .clk(clk), .rst_n(rst_n), .din(din), .irdy(irdy), .coeff(coeff), .loadc(loadc),
        .dout(dout1), .ordy(ordy1));

    // no symmetry, unsigned, fixed coefficients, full 12-bit output
    bsfir_top #(.DW(4), .NTAPS(6), .SYM(bsf_pkg::SYM_NONE), .SIGNED(1'b0), .LOADABLE(1'b0),
                .OW(12), .ROUND(1'b0), .COEF_INIT(24'hC917F3)) u2 (
        .clk(clk), .rst_n(rst_n), .din(din), .irdy(irdy), .coeff(coeff), .loadc(loadc),
        .dout(dout2), .ordy(ordy2));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit fin = 1'b0;

    logic [3:0] hist [6];
    int cs [3];
    int fc [6] = '{3, 15, 7, 1, 9, 12};
    int exp0 [1024];
    int exp1 [1024];
    int exp2 [1024];
    int acyc [1024];
    int n = 0;
    int r0 = 0, r1 = 0, r2 = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sx(input logic [3:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send(input logic [3:0] x);
        int y0, y1, y2;
        @(negedge clk);
        din  = x;
        irdy = 1'b1;
        @(negedge clk);
        irdy = 1'b0;
        acyc[n] = cyc;
        for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        y0 = 0; y1 = 0; y2 = 0;
        for (int k = 0; k < 3; k++) begin
            y0 += cs[k] * (sx(hist[k]) + sx(hist[5-k]));
            y1 += cs[k] * (sx(hist[k]) - sx(hist[5-k]));
        end
        for (int k = 0; k < 6; k++) y2 += fc[k] * int'(hist[k]);
        exp0[n] = (y0 + 8) >>> 4;
        exp1[n] = y1 >>> 2;
        exp2[n] = y2;
        n++;
        repeat (12) @(negedge clk);
    endtask

    // words a,b,c shifted in: c ends in word 0, a in word 2
    task automatic load3(input int a, input int b, input int c);
        int w [3];
        w[0] = a; w[1] = b; w[2] = c;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            coeff = w[i][3:0];
            loadc = 1'b1;
        end
        @(negedge clk);
        loadc = 1'b0;
        cs[0] = c; cs[1] = b; cs[2] = a;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ordy0) begin
                if (r0 < n) begin
                    chk(dout0 == exp0[r0][6:0], "R3/R7 even rounded result", int'($signed(dout0)), exp0[r0]);
                    chk(cyc - acyc[r0] == LAT, "R8 even latency", cyc - acyc[r0], LAT);
                end else chk(1'b0, "R1 extra even result", r0, n);
                r0++;
            end
            if (ordy1) begin
                if (r1 < n) begin
                    chk(dout1 == exp1[r1][8:0], "R4/R7 odd truncated result", int'($signed(dout1)), exp1[r1]);
                    chk(cyc - acyc[r1] == LAT, "R4/R8 odd latency", cyc - acyc[r1], LAT);
                end else chk(1'b0, "R1 extra odd result", r1, n);
                r1++;
            end
            if (ordy2) begin
                if (r2 < n) begin
                    chk(dout2 == exp2[r2][11:0], "R5/R6 unsigned fixed result", int'(dout2), exp2[r2]);
                    chk(cyc - acyc[r2] == LAT, "R8 plain latency", cyc - acyc[r2], LAT);
                end else chk(1'b0, "R1 extra plain result", r2, n);
                r2++;
            end
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) hist[i] = '0;
        cs[0] = 2; cs[1] = -3; cs[2] = 5;
        repeat (4) @(negedge clk);
        chk(ordy0 == 1'b0 && ordy1 == 1'b0 && ordy2 == 1'b0, "R10 ordy low in reset", ordy0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout0 == '0 && dout1 == '0 && dout2 == '0, "R10 dout zero after reset", int'(dout0), 0);
        chk(ordy0 == 1'b0, "R10 ordy low after reset", ordy0, 0);

        // R2 R6: reset coefficients, cleared taps, every value once
        for (int v = 0; v < 16; v++) send(4'(v));

        // R6: loading reorders; fixed-coefficient instance must not change
        load3(7, -8, -1);
        for (int v = 15; v >= 0; v--) send(4'(v));
        for (int i = 0; i < 6; i++) send(4'h8);

        // R1: irdy pulses inside a running period are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            din = 4'(i + 3); irdy = 1'b1;
            @(negedge clk);
            irdy = 1'b0;
            acyc[n] = cyc;
            for (int s = 5; s > 0; s--) hist[s] = hist[s-1];
            hist[0] = 4'(i + 3);
            begin
                int y0, y1, y2;
                y0 = 0; y1 = 0; y2 = 0;
                for (int k = 0; k < 3; k++) begin
                    y0 += cs[k] * (sx(hist[k]) + sx(hist[5-k]));
                    y1 += cs[k] * (sx(hist[k]) - sx(hist[5-k]));
                end
                for (int k = 0; k < 6; k++) y2 += fc[k] * int'(hist[k]);
                exp0[n] = (y0 + 8) >>> 4; exp1[n] = y1 >>> 2; exp2[n] = y2;
            end
            n++;
            repeat (2 + i) @(negedge clk);
            din = 4'hF; irdy = 1'b1;
            @(negedge clk);
            irdy = 1'b0;
            repeat (12 - i) @(negedge clk);
        end

        // R3 R4 R7: most negative coefficients, then every consecutive pair
        load3(-8, -8, -8);
        for (int i = 0; i < 6; i++) send(4'h7);
        for (int i = 0; i < 6; i++) send(4'h8);
        load3(3, -5, 6);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                send(4'(a));
                send(4'(b));
            end
        end

        repeat (40) @(negedge clk);
        chk(r0 == n, "R1 even result count", r0, n);
        chk(r1 == n, "R1 odd result count", r1, n);
        chk(r2 == n, "R1 plain result count", r2, n);
        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", r0, n);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule